// File: doc/BRIEF.md
# DMA Channel Event and Interrupt Aggregator

This block gathers single-cycle event pulses from up to sixteen DMA channels and turns them into software-visible state and one interrupt line. Each channel can raise three kinds of event: transfer done, fault class A and fault class B. Every class has its own sticky raw latch, its own enable mask and a masked view. A summary word shows, per channel, whether any enabled event is pending. The interrupt output is high while that summary is non-zero.

Software enables the channels it cares about by writing the mask words. When the interrupt fires, it reads the summary and masked words to find the source. It then acknowledges by writing ones into the raw latch. The block also samples a per-channel busy vector into a read-only word, and it holds a channel priority word that software can read and write. Register reads are combinational from a simple address/data port, and writes take effect at the clock edge.

Top module: `dma_irq_aggregator`

## Requirements
- R1: After reset every raw latch, every mask, the priority word and the busy word read as zero, and `irq_o` is low.
- R2: A one on bit i of `evt_done_i`, `evt_flt_a_i` or `evt_flt_b_i` in a cycle sets bit i of that class's raw latch at that clock edge. The bit stays set until it is cleared. Raw latches are read at 0x600 (done), 0x608 (fault A) and 0x610 (fault B).
- R3: A write to a raw latch offset clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R4: When an event for bit i and a clearing write of bit i reach the same latch in the same cycle, the bit ends set.
- R5: The mask words are written and read at 0x018 (done), 0x020 (fault A) and 0x024 (fault B). A mask bit of 1 enables that channel's event. A write of 0xFFFF enables all sixteen channels and a write of 0 disables them.
- R6: The masked words read at 0x004 (done), 0x00C (fault A) and 0x010 (fault B) equal the raw latch ANDed with its mask.
- R7: Bit i of the summary word at 0x000 is set when channel i has an enabled pending event in any of the three classes.
- R8: `irq_o` is high exactly when the summary word is non-zero.
- R9: The word at 0x690 shows `chan_busy_i` as sampled at the previous clock edge, and writes to it have no effect.
- R10: The priority word at 0x688 is read/write over the full data width. Writing 0 sets all channels to equal priority.
- R11: Reads of unmapped offsets return zero. Writes to unmapped, summary or masked offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_done_i | input | NUM_CH | Per-channel transfer-done pulses |
| evt_flt_a_i | input | NUM_CH | Per-channel fault class A pulses |
| evt_flt_b_i | input | NUM_CH | Per-channel fault class B pulses |
| chan_busy_i | input | NUM_CH | Per-channel busy level |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i` |
| irq_o | output | 1 | Aggregated interrupt |

## Verification
The assertions assume that the event inputs are sampled only at clock edges and that a write strobe and its address are stable across the edge that commits them. They also assume no write is issued while reset is asserted. The stimulus keeps to these assumptions: all inputs change only on the falling clock edge, every write and event pulse lasts exactly one cycle, and no traffic starts until reset has been released. The same-cycle case of a set and a clear on one bit is produced on purpose, by driving a pulse and a clearing write in the same half cycle.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
    localparam int NUM_CLASSES = 3;

    // Byte offsets; software decodes these, so they are fixed.
    localparam logic [11:0] OFS_SUMMARY  = 12'h000;
    localparam logic [11:0] OFS_PRIORITY = 12'h688;
    localparam logic [11:0] OFS_BUSY     = 12'h690;

    // Per class: index 0 = done, 1 = fault A, 2 = fault B
    localparam logic [11:0] OFS_MASKED [NUM_CLASSES] = '{12'h004, 12'h00C, 12'h010};
    localparam logic [11:0] OFS_ENABLE [NUM_CLASSES] = '{12'h018, 12'h020, 12'h024};
    localparam logic [11:0] OFS_RAW    [NUM_CLASSES] = '{12'h600, 12'h608, 12'h610};
endpackage

// File: rtl/dma_irq_evt_bank.sv
module dma_irq_evt_bank #(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] evt_i,
    input  logic              clr_we_i,
    input  logic              mask_we_i,
    input  logic [NUM_CH-1:0] wdata_i,
    output logic [NUM_CH-1:0] raw_o,
    output logic [NUM_CH-1:0] mask_o,
    output logic [NUM_CH-1:0] pend_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] raw;
        logic [NUM_CH-1:0] mask;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_we_i) begin
            st_d.raw = st_q.raw & ~wdata_i;
        end
        // A new event overrides a same-cycle clear
        st_d.raw = st_d.raw | evt_i;
        if (mask_we_i) begin
            st_d.mask = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_o  = st_q.raw;
    assign mask_o = st_q.mask;
    assign pend_o = st_q.raw & st_q.mask;

    // R2: every pulsed bit is latched
    a_r2_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((raw_o & $past(evt_i)) == $past(evt_i)));

    // R3: cleared bits without a competing event drop
    a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i |=> ((raw_o & $past(wdata_i & ~evt_i)) == '0));

    // R4: set beats clear on the same bit
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we_i && ((wdata_i & evt_i) != '0))
            |=> ((raw_o & $past(wdata_i & evt_i)) == $past(wdata_i & evt_i)));

    // R3: without events or clears the latch holds
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_we_i && evt_i == '0) |=> $stable(raw_o));
endmodule

// File: rtl/dma_irq_read_mux.sv
module dma_irq_read_mux
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0]                  addr_i,
    input  logic [NUM_CLASSES-1:0][NUM_CH-1:0] raw_i,
    input  logic [NUM_CLASSES-1:0][NUM_CH-1:0] mask_i,
    input  logic [NUM_CLASSES-1:0][NUM_CH-1:0] pend_i,
    input  logic [NUM_CH-1:0]                  summary_i,
    input  logic [NUM_CH-1:0]                  busy_i,
    input  logic [DATA_W-1:0]                  prio_i,
    output logic [DATA_W-1:0]                  rdata_o
);
    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(OFS_SUMMARY)) begin
            rdata_o = DATA_W'(summary_i);
        end
        if (addr_i == ADDR_W'(OFS_BUSY)) begin
            rdata_o = DATA_W'(busy_i);
        end
        if (addr_i == ADDR_W'(OFS_PRIORITY)) begin
            rdata_o = prio_i;
        end
        for (int k = 0; k < NUM_CLASSES; k++) begin
            if (addr_i == ADDR_W'(OFS_RAW[k])) begin
                rdata_o = DATA_W'(raw_i[k]);
            end
            if (addr_i == ADDR_W'(OFS_ENABLE[k])) begin
                rdata_o = DATA_W'(mask_i[k]);
            end
            if (addr_i == ADDR_W'(OFS_MASKED[k])) begin
                rdata_o = DATA_W'(pend_i[k]);
            end
        end
    end
endmodule

// File: rtl/dma_irq_aggregator.sv
module dma_irq_aggregator
    import dma_irq_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] evt_done_i,
    input  logic [NUM_CH-1:0] evt_flt_a_i,
    input  logic [NUM_CH-1:0] evt_flt_b_i,
    input  logic [NUM_CH-1:0] chan_busy_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] busy;
        logic [DATA_W-1:0] prio;
    } ctl_state_t;

    ctl_state_t ctl_d, ctl_q;

    logic [NUM_CLASSES-1:0][NUM_CH-1:0] evt_w;
    logic [NUM_CLASSES-1:0][NUM_CH-1:0] raw_w;
    logic [NUM_CLASSES-1:0][NUM_CH-1:0] mask_w;
    logic [NUM_CLASSES-1:0][NUM_CH-1:0] pend_w;
    logic [NUM_CH-1:0]                  summary_w;

    assign evt_w[0] = evt_done_i;
    assign evt_w[1] = evt_flt_a_i;
    assign evt_w[2] = evt_flt_b_i;

    for (genvar k = 0; k < NUM_CLASSES; k++) begin : g_class
        logic clr_we, mask_we;
        assign clr_we  = wr_en_i && (addr_i == ADDR_W'(OFS_RAW[k]));
        assign mask_we = wr_en_i && (addr_i == ADDR_W'(OFS_ENABLE[k]));

        dma_irq_evt_bank #(.NUM_CH(NUM_CH)) bank_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_i     (evt_w[k]),
            .clr_we_i  (clr_we),
            .mask_we_i (mask_we),
            .wdata_i   (wdata_i[NUM_CH-1:0]),
            .raw_o     (raw_w[k]),
            .mask_o    (mask_w[k]),
            .pend_o    (pend_w[k])
        );
    end

    always_comb begin
        summary_w = '0;
        for (int k = 0; k < NUM_CLASSES; k++) begin
            summary_w = summary_w | pend_w[k];
        end
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.busy = chan_busy_i;
        if (wr_en_i && addr_i == ADDR_W'(OFS_PRIORITY)) begin
            ctl_d.prio = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    dma_irq_read_mux #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) rmux_i (
        .addr_i    (addr_i),
        .raw_i     (raw_w),
        .mask_i    (mask_w),
        .pend_i    (pend_w),
        .summary_i (summary_w),
        .busy_i    (ctl_q.busy),
        .prio_i    (ctl_q.prio),
        .rdata_o   (rdata_o)
    );

    assign irq_o = |summary_w;

    // R8: interrupt tracks enabled raw events across all banks
    a_r8_irq_matches_banks: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (((raw_w[0] & mask_w[0]) | (raw_w[1] & mask_w[1])
                 | (raw_w[2] & mask_w[2])) != '0));

    // R10: priority only moves on a write to its offset
    a_r10_prio_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && addr_i == ADDR_W'(OFS_PRIORITY)) |=> $stable(ctl_q.prio));
endmodule

// File: tb/dma_irq_aggregator_tb_top.sv
`timescale 1ns/100ps
module dma_irq_aggregator_tb_top;
    localparam int NUM_CH = 16;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_CH-1:0] evt_done = '0, evt_fa = '0, evt_fb = '0, busy = '0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dma_irq_aggregator #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
        .clk (clk), .rst_n (rst_n),
        .evt_done_i (evt_done), .evt_flt_a_i (evt_fa), .evt_flt_b_i (evt_fb),
        .chan_busy_i (busy), .wr_en_i (wr_en), .addr_i (addr),
        .wdata_i (wdata), .rdata_o (rdata), .irq_o (irq)
    );

    // kind: 0 write, 1 read-check, 2 pulse done, 3 pulse fault A, 4 pulse fault B
    typedef struct packed {
        logic [2:0]  kind;
        logic [11:0] ofs;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 12'h018, 32'h0000_000F, 4'd5},  // R5 enable done ch0-3
        '{3'd2, 12'h000, 32'h0000_0011, 4'd2},  // R2 pulse ch0, ch4
        '{3'd1, 12'h600, 32'h0000_0011, 4'd2},
        '{3'd1, 12'h004, 32'h0000_0001, 4'd6},  // R6
        '{3'd1, 12'h000, 32'h0000_0001, 4'd7},  // R7
        '{3'd0, 12'h020, 32'h0000_0010, 4'd5},
        '{3'd3, 12'h000, 32'h0000_0030, 4'd2},
        '{3'd1, 12'h608, 32'h0000_0030, 4'd2},
        '{3'd1, 12'h00C, 32'h0000_0010, 4'd6},
        '{3'd1, 12'h000, 32'h0000_0011, 4'd7},
        '{3'd0, 12'h600, 32'h0000_0001, 4'd3},  // R3 clear ch0 only
        '{3'd1, 12'h600, 32'h0000_0010, 4'd3},
        '{3'd1, 12'h000, 32'h0000_0010, 4'd7},
        '{3'd0, 12'h608, 32'h0000_0030, 4'd3},
        '{3'd1, 12'h000, 32'h0000_0000, 4'd7},
        '{3'd0, 12'h024, 32'h0000_FFFF, 4'd5},  // fault B path
        '{3'd4, 12'h000, 32'h0000_8000, 4'd2},
        '{3'd1, 12'h010, 32'h0000_8000, 4'd6}
    };

    task automatic check(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic reg_check(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp,
                             input string req);
        @(negedge clk);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic pulse(input int cls, input logic [NUM_CH-1:0] bits);
        @(negedge clk);
        if (cls == 0) evt_done = bits;
        if (cls == 1) evt_fa = bits;
        if (cls == 2) evt_fb = bits;
        @(negedge clk);
        evt_done = '0; evt_fa = '0; evt_fb = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_check(12'h600, 32'h0, "R1");
        reg_check(12'h018, 32'h0, "R1");
        reg_check(12'h688, 32'h0, "R1");
        reg_check(12'h690, 32'h0, "R1");
        check("R1", {31'b0, irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[i].req);
            case (VECS[i].kind)
                3'd0: reg_write(VECS[i].ofs, VECS[i].data);
                3'd1: reg_check(VECS[i].ofs, VECS[i].data, tag);
                3'd2: pulse(0, VECS[i].data[NUM_CH-1:0]);
                3'd3: pulse(1, VECS[i].data[NUM_CH-1:0]);
                default: pulse(2, VECS[i].data[NUM_CH-1:0]);
            endcase
        end

        // R8 interrupt high with pending fault B ch15 and done ch4 masked off
        @(negedge clk); #1;
        check("R8", {31'b0, irq}, 32'h1);
        reg_write(12'h024, 32'h0);
        @(negedge clk); #1;
        check("R8", {31'b0, irq}, 32'h0);
        reg_check(12'h024, 32'h0, "R5");

        // R4 set wins over clear on same bit, other cleared bit drops
        pulse(0, 16'h0002);
        @(negedge clk);
        wr_en = 1'b1; addr = 12'h600; wdata = 32'h0000_0012; evt_done = 16'h0002;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0; evt_done = '0;
        reg_check(12'h600, 32'h0000_0002, "R4");

        // R9 busy sampling, write ignored
        @(negedge clk);
        busy = 16'hA5C3;
        reg_check(12'h690, 32'h0000_A5C3, "R9");
        reg_write(12'h690, 32'h0000_FFFF);
        reg_check(12'h690, 32'h0000_A5C3, "R9");

        // R10 priority read/write
        reg_write(12'h688, 32'hDEAD_BEEF);
        reg_check(12'h688, 32'hDEAD_BEEF, "R10");
        reg_write(12'h688, 32'h0);
        reg_check(12'h688, 32'h0, "R10");

        // R11 unmapped read zero, writes to read-only offsets ignored
        reg_write(12'h700, 32'hFFFF_FFFF);
        reg_check(12'h700, 32'h0, "R11");
        reg_write(12'h004, 32'hFFFF_FFFF);
        reg_write(12'h000, 32'hFFFF_FFFF);
        reg_check(12'h600, 32'h0000_0002, "R11");
        reg_check(12'h018, 32'h0000_000F, "R11");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule